// File: doc/BRIEF.md
# Shared UART Bit-Rate Tick Generator

This block supplies all bit timing for a UART whose transmitter and receiver run from one counter on the peripheral clock. A 16-bit divisor gives the length of a whole bit in clock cycles, so the bit rate is the clock frequency divided by the divisor. From that one period the block gives the transmitter a single strobe per bit. It gives the receiver sixteen sub-bit strobes per bit for oversampling. The divisor does not have to be a multiple of sixteen, so these sixteen strobes are spread by a phase accumulator. It adds sixteen per clock and wraps at the divisor. The result is that neighbouring strobes differ in spacing by no more than one clock.

The divisor register can be written only while both the transmit enable and the receive enable are low. A divisor of sixteen or less is reported as an invalid configuration, and no strobes come out while it is loaded. When either enable falls, the bit counter restarts from zero and a sticky interrupt flag is set. Software clears that flag with a write-one-to-clear pulse, and an interrupt-enable bit gates the flag onto the interrupt output.

Top module: `shared_baud_gen`

## Requirements
- R1: After reset the divisor reads 0, `cfgInvalid` is 1, `irqFlag` and `irqOut` are 0, and no strobes are produced.
- R2: While running, `bitTick` is high on the DIV-th cycle of every DIV-cycle period. The first period starts on the first cycle in which an enable is high with a valid divisor.
- R3: In running cycle k of a period (k = 1..DIV), `sampleTick` is high exactly when floor(16k/DIV) > floor(16(k-1)/DIV). This gives 16 strobes per period, and the first one falls in cycle ceil(DIV/16).
- R4: Every `bitTick` coincides with a `sampleTick`, which is the sixteenth strobe of its period.
- R5: A divisor of 16 or less drives `cfgInvalid` high, and no strobe appears even with an enable high.
- R6: A divisor write (`divWrEn` high) takes effect at the next clock edge only while `txEnable` and `rxEnable` are both low. Otherwise the stored value is kept.
- R7: A falling edge on `txEnable` or `rxEnable` sets `irqFlag` at the next edge. That cycle produces no strobe, and the period restarts from zero on the following cycle.
- R8: `irqFlag` stays set until a cycle with `irqClear` high and no new disable event. A disable event in the same cycle as `irqClear` leaves the flag set.
- R9: `irqOut` is high exactly when `irqFlag` and `irqEnable` are both high.
- R10: With both enables low, no strobe is produced, whatever the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| divWrEn | input | 1 | Divisor write strobe |
| divWrData | input | 16 | Divisor write value |
| txEnable | input | 1 | Transmitter enable |
| rxEnable | input | 1 | Receiver enable |
| irqEnable | input | 1 | Interrupt enable |
| irqClear | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| divisor | output | 16 | Stored divisor |
| cfgInvalid | output | 1 | Stored divisor is 16 or less |
| bitTick | output | 1 | One strobe per bit period |
| sampleTick | output | 1 | Sixteen oversampling strobes per bit period |
| irqFlag | output | 1 | Sticky disable interrupt flag |
| irqOut | output | 1 | Gated interrupt request |

## Verification
A wrong phase accumulator value shows up within one bit period as a sample strobe on the wrong cycle, or as a period with fifteen or seventeen strobes. A bit counter that fails to restart shows up as a `bitTick` that is not DIV cycles after an enable rise or a disable event. Each of these is caught by comparing every cycle against the floor formula across divisors that do and do not divide by sixteen. A broken write lock or broken flag logic shows up at the divisor readback and at `irqFlag` one cycle after the event.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic run;      // an enable is high and divisor is valid
    logic restart;  // an enable fell this cycle
  } baudCtrl_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_gen_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  input  logic             txEnable,
  input  logic             rxEnable,
  input  logic             irqEnable,
  input  logic             irqClear,
  output logic [DIV_W-1:0] divisor,
  output logic             cfgInvalid,
  output logic             irqFlag,
  output logic             irqOut,
  output baudCtrl_t        ctrl
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(OVS);

  logic txPrev, rxPrev;
  logic anyEnable, disableEvt;
  logic [DIV_W-1:0] divReg;
  logic flagReg;

  assign anyEnable  = txEnable | rxEnable;
  assign disableEvt = (txPrev & ~txEnable) | (rxPrev & ~rxEnable);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPrev  <= 1'b0;
      rxPrev  <= 1'b0;
      divReg  <= '0;
      flagReg <= 1'b0;
    end else begin
      txPrev <= txEnable;
      rxPrev <= rxEnable;
      if (divWrEn && !anyEnable) divReg <= divWrData;
      if (disableEvt)    flagReg <= 1'b1;
      else if (irqClear) flagReg <= 1'b0;
    end
  end

  assign divisor      = divReg;
  assign cfgInvalid   = (divReg <= MIN_DIV);
  assign irqFlag      = flagReg;
  assign irqOut       = flagReg & irqEnable;
  assign ctrl.run     = anyEnable & ~cfgInvalid;
  assign ctrl.restart = disableEvt;
endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_gen_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  baudCtrl_t        ctrl,
  input  logic [DIV_W-1:0] divisor,
  output logic             bitTick,
  output logic             sampleTick
);
  localparam int ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] ACC_STEP = ACC_W'(OVS);

  logic [DIV_W-1:0] bitCnt;
  logic [ACC_W-1:0] phaseAcc, accSum, divExt;
  logic active, sampleHit, lastCycle;

  assign active    = ctrl.run & ~ctrl.restart;
  assign divExt    = {1'b0, divisor};
  assign accSum    = phaseAcc + ACC_STEP;
  assign sampleHit = active && (accSum >= divExt);
  assign lastCycle = active && (bitCnt == divisor - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      bitCnt   <= '0;
      phaseAcc <= '0;
    end else begin
      bitCnt   <= lastCycle ? '0 : bitCnt + 1'b1;
      phaseAcc <= sampleHit ? accSum - divExt : accSum;
    end
  end

  assign bitTick    = lastCycle;
  assign sampleTick = sampleHit;
endmodule

// File: rtl/shared_baud_gen.sv
module shared_baud_gen
  import baud_gen_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  input  logic             txEnable,
  input  logic             rxEnable,
  input  logic             irqEnable,
  input  logic             irqClear,
  output logic [DIV_W-1:0] divisor,
  output logic             cfgInvalid,
  output logic             bitTick,
  output logic             sampleTick,
  output logic             irqFlag,
  output logic             irqOut
);
  baudCtrl_t ctrl;

  baud_ctrl #(.DIV_W(DIV_W), .OVS(OVS)) i_ctrl (
    .clk(clk), .rstN(rstN), .divWrEn(divWrEn), .divWrData(divWrData),
    .txEnable(txEnable), .rxEnable(rxEnable), .irqEnable(irqEnable),
    .irqClear(irqClear), .divisor(divisor), .cfgInvalid(cfgInvalid),
    .irqFlag(irqFlag), .irqOut(irqOut), .ctrl(ctrl)
  );

  baud_datapath #(.DIV_W(DIV_W), .OVS(OVS)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .divisor(divisor),
    .bitTick(bitTick), .sampleTick(sampleTick)
  );
endmodule

// File: rtl/shared_baud_gen_chk.sv
module shared_baud_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             txEnable,
  input logic             rxEnable,
  input logic             irqClear,
  input logic [DIV_W-1:0] divisor,
  input logic             cfgInvalid,
  input logic             bitTick,
  input logic             sampleTick,
  input logic             irqFlag
);
  AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rstN) bitTick |-> sampleTick); // R4
  AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rstN) cfgInvalid |-> (!sampleTick && !bitTick)); // R5
  AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rstN) (txEnable || rxEnable) |=> $stable(divisor)); // R6
  AST_DISABLE_IRQ: assert property (@(posedge clk) disable iff (!rstN) ($fell(txEnable) || $fell(rxEnable)) |=> irqFlag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN) (irqFlag && !irqClear) |=> irqFlag); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN) (!txEnable && !rxEnable) |-> (!sampleTick && !bitTick)); // R10
endmodule

bind shared_baud_gen shared_baud_gen_chk #(.DIV_W(DIV_W)) i_chk (.*);

// File: tb/test_shared_baud_gen.sv
`timescale 1ns/1ps
module test_shared_baud_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic divWrEn = 1'b0;
  logic [15:0] divWrData = '0;
  logic txEnable = 1'b0, rxEnable = 1'b0, irqEnable = 1'b0, irqClear = 1'b0;
  logic [15:0] divisor;
  logic cfgInvalid, bitTick, sampleTick, irqFlag, irqOut;

  int testsRun = 0;
  int testsFailed = 0;

  localparam int VEC_N = 8;
  localparam int VEC_DIV  [VEC_N] = '{17, 20, 32, 33, 47, 100, 255, 1000};
  localparam int VEC_FIRST[VEC_N] = '{ 2,  2,  2,  3,  3,   7,  16,   63};

  always #2.5 clk = ~clk;

  shared_baud_gen i_shared_baud_gen (
    .clk(clk), .rstN(rstN), .divWrEn(divWrEn), .divWrData(divWrData),
    .txEnable(txEnable), .rxEnable(rxEnable), .irqEnable(irqEnable),
    .irqClear(irqClear), .divisor(divisor), .cfgInvalid(cfgInvalid),
    .bitTick(bitTick), .sampleTick(sampleTick), .irqFlag(irqFlag), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #0.5;
  endtask

  task automatic writeDiv(input int value);
    divWrEn = 1'b1;
    divWrData = 16'(value);
    cyc();
    divWrEn = 1'b0;
  endtask

  task automatic dropAll();
    txEnable = 1'b0;
    rxEnable = 1'b0;
    cyc();
    irqClear = 1'b1;
    cyc();
    irqClear = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int ticks;
    int firstBit;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1: reset state
    #0.5;
    check(divisor == 16'd0, "R1 divisor", divisor, 0);
    check(cfgInvalid == 1'b1, "R1 cfgInvalid", cfgInvalid, 1);
    check(irqFlag == 1'b0 && irqOut == 1'b0, "R1 irq", irqFlag, 0);
    check(!bitTick && !sampleTick, "R1 ticks", sampleTick, 0);
    cyc();

    // R5: divisor 16 is invalid, no ticks even enabled
    writeDiv(16);
    check(cfgInvalid == 1'b1, "R5 cfgInvalid at 16", cfgInvalid, 1);
    txEnable = 1'b1;
    ticks = 0;
    for (int i = 0; i < 40; i++) begin
      #0.5;
      ticks += int'(sampleTick) + int'(bitTick);
      cyc();
    end
    check(ticks == 0, "R5 no ticks when invalid", ticks, 0);
    dropAll();

    // R2 R3 R4: vector table walk
    for (int v = 0; v < VEC_N; v++) begin
      int dv;
      int sMis, bMis, cMis, sCnt, bCnt, first;
      dv = VEC_DIV[v];
      writeDiv(dv);
      check(cfgInvalid == 1'b0 && divisor == 16'(dv), "R6 write while idle", divisor, dv);
      txEnable = 1'b1;
      sMis = 0; bMis = 0; cMis = 0; sCnt = 0; bCnt = 0; first = 0;
      for (int k = 1; k <= 2 * dv; k++) begin
        int kk;
        bit expS, expB;
        kk = ((k - 1) % dv) + 1;
        expS = ((16 * kk) / dv) != ((16 * (kk - 1)) / dv);
        expB = (kk == dv);
        #0.5;
        if (sampleTick !== expS) sMis++;
        if (bitTick !== expB) bMis++;
        if (bitTick && !sampleTick) cMis++;
        if (sampleTick) begin
          sCnt++;
          if (first == 0) first = k;
        end
        if (bitTick) bCnt++;
        cyc();
      end
      check(sMis == 0, "R3 sample pattern", sMis, 0);
      check(sCnt == 32, "R3 sixteen per period", sCnt, 32);
      check(first == VEC_FIRST[v], "R3 first sample", first, VEC_FIRST[v]);
      check(bMis == 0 && bCnt == 2, "R2 bit strobe", bCnt, 2);
      check(cMis == 0, "R4 bit with sample", cMis, 0);
      dropAll();
    end

    // R6: writes locked while enabled
    writeDiv(40);
    rxEnable = 1'b1;
    writeDiv(99);
    check(divisor == 16'd40, "R6 locked write", divisor, 40);
    // R7: receiver disable sets flag
    rxEnable = 1'b0;
    cyc();
    check(irqFlag == 1'b1, "R7 flag on rx disable", irqFlag, 1);
    // R9: gating
    check(irqOut == 1'b0, "R9 irqOut gated off", irqOut, 0);
    irqEnable = 1'b1;
    #0.5;
    check(irqOut == 1'b1, "R9 irqOut enabled", irqOut, 1);
    cyc();
    // R8: stays set, set wins over clear
    repeat (5) cyc();
    check(irqFlag == 1'b1, "R8 flag held", irqFlag, 1);
    txEnable = 1'b1;
    cyc();
    txEnable = 1'b0;
    irqClear = 1'b1;
    cyc();
    check(irqFlag == 1'b1, "R8 set wins", irqFlag, 1);
    cyc();
    irqClear = 1'b0;
    check(irqFlag == 1'b0, "R8 cleared", irqFlag, 0);
    #0.5;
    check(irqOut == 1'b0, "R9 irqOut low after clear", irqOut, 0);
    cyc();
    writeDiv(99);
    check(divisor == 16'd99, "R6 write after disable", divisor, 99);
    writeDiv(40);

    // R7: restart on rx disable with tx still enabled
    txEnable = 1'b1;
    rxEnable = 1'b1;
    repeat (25) cyc();
    rxEnable = 1'b0;
    #0.5;
    check(!sampleTick && !bitTick, "R7 silent restart cycle", sampleTick, 0);
    cyc();
    check(irqFlag == 1'b1, "R7 flag on restart", irqFlag, 1);
    firstBit = 0;
    for (int k = 1; k <= 45; k++) begin
      #0.5;
      if (bitTick && firstBit == 0) firstBit = k;
      cyc();
    end
    check(firstBit == 40, "R7 period restarts", firstBit, 40);
    dropAll();

    // R10: idle with valid divisor
    ticks = 0;
    for (int i = 0; i < 60; i++) begin
      #0.5;
      ticks += int'(sampleTick) + int'(bitTick);
      cyc();
    end
    check(ticks == 0, "R10 idle silent", ticks, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule